// File: doc/BRIEF.md
# Host OUT Endpoint Transmit Sequencer

This block drives one transmit endpoint on the host side of a serial bus controller. A producer, either software or a DMA engine, pushes payload bytes into a transmit buffer. Here the buffer is modelled only by its byte count, with a flush control. Raising a commit flag marks the buffered packet as ready. The sequencer then holds a request to an external transaction engine until that engine returns a handshake result. The engine issues the OUT token and the data phase. The sequencer applies the retry policy to that result, updates sticky status bits and pulses a completion interrupt when the packet leaves the endpoint, whether it succeeded or not.

An auto-commit mode is provided for bulk streaming. In this mode the packet is committed as soon as the loaded byte count reaches the programmed maximum packet size, so a DMA engine can run a whole transfer without software acting on each packet. NAK handshakes are retried up to a programmable limit. A limit of zero means the sequencer retries for as long as NAKs keep arriving. STALL handshakes end the packet at once. Timeouts and corrupted handshakes are retried, and the third failure flushes the buffer and raises an error.

Top module: `host_out_tx_seq`

## Requirements
- R1: After reset the byte count, commit flag, request, interrupt and all status bits (stalled, error, NAK limit, overrun) are 0.
- R2: Each cycle with `wr_en_i` high, while the flag is clear and the count is below `FIFO_DEPTH`, adds one to `fifo_cnt_o`. A write when the count equals `FIFO_DEPTH` is dropped and sets `overrun_o`.
- R3: A pulse on `commit_i` sets `ready_o` on the next edge. `txn_req_o` rises one cycle after that, with `txn_len_o` equal to the byte count.
- R4: When `auto_commit_i` is high, the write that brings the count to `max_pkt_i` also sets `ready_o` on the same edge.
- R5: While `ready_o` is high, writes leave `fifo_cnt_o` unchanged and set `overrun_o`.
- R6: A response is taken only when `txn_done_i` is high while `txn_req_o` is high. The response code is 0 for ACK, 1 for NAK, 2 for STALL and 3 for a bus error (timeout or corrupted handshake). On ACK, `ready_o` and `txn_req_o` drop, `fifo_cnt_o` returns to 0 and `tx_irq_o` pulses for exactly one cycle.
- R7: A NAK keeps `txn_req_o` high. When `nak_limit_i` is nonzero, the NAK that brings the count of NAKs for this packet to `nak_limit_i` ends the packet: `nak_to_o` is set, `ready_o` drops, `tx_irq_o` pulses and the byte count is kept.
- R8: With `nak_limit_i` equal to 0, NAKs are retried without any bound.
- R9: A STALL is not retried. It sets `stalled_o`, drops `ready_o` and the request, pulses `tx_irq_o` and keeps the byte count.
- R10: A bus error keeps the request high. The third bus error for a packet flushes the count to 0, sets `error_o`, drops `ready_o` and pulses `tx_irq_o`.
- R11: The NAK and bus-error counts restart for every new packet.
- R12: `flush_i` clears the byte count while `ready_o` is low, and has no effect while `ready_o` is high.
- R13: `status_clr_i` clears `stalled_o`, `error_o`, `nak_to_o` and `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Load one byte into the transmit buffer |
| flush_i | input | 1 | Empty the buffer while idle |
| commit_i | input | 1 | Mark the loaded packet ready to send |
| auto_commit_i | input | 1 | Commit automatically on a full-size load |
| max_pkt_i | input | CNT_W | Maximum packet size in bytes |
| nak_limit_i | input | NAK_W | NAK count that ends a packet, 0 for no limit |
| status_clr_i | input | 1 | Clear the sticky status bits |
| txn_req_o | output | 1 | Request an OUT transaction from the engine |
| txn_len_o | output | CNT_W | Payload length of the request |
| txn_done_i | input | 1 | Engine handshake result is valid |
| txn_resp_i | input | 2 | Handshake code: 0 ACK, 1 NAK, 2 STALL, 3 bus error |
| ready_o | output | 1 | Packet committed and not yet finished |
| fifo_cnt_o | output | CNT_W | Bytes in the transmit buffer |
| tx_irq_o | output | 1 | One-cycle pulse when a packet finishes |
| stalled_o | output | 1 | Sticky: endpoint answered STALL |
| error_o | output | 1 | Sticky: bus-error retries exhausted |
| nak_to_o | output | 1 | Sticky: NAK limit reached |
| overrun_o | output | 1 | Sticky: a write was dropped |

## Verification
The bench builds the block with `FIFO_DEPTH` = 16 and `NAK_W` = 4. With a buffer this shallow, filling it to the full mark and reaching the overrun on a full buffer take only a few cycles. It also lets `max_pkt_i` be set both below and at the depth to exercise auto-commit. With four NAK-limit bits, the limit can be set to a small value such as 3 to reach the abort. Setting the limit to 0 and sending twenty NAKs goes past the point where any nonzero limit that fits in four bits would have ended the packet. The error budget keeps its default of three tries, so both the flush on the third error and the counter restart across two packets can be reached.

// File: rtl/host_tx_pkg.sv
package host_tx_pkg;
  typedef enum logic [1:0] {
    RESP_ACK   = 2'd0,
    RESP_NAK   = 2'd1,
    RESP_STALL = 2'd2,
    RESP_ERR   = 2'd3
  } resp_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tx_fifo_cnt.sv
module tx_fifo_cnt #(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             locked_i,
  input  logic             flush_i,
  input  logic             clr_i,
  input  logic             auto_commit_i,
  input  logic [CNT_W-1:0] max_pkt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             overrun_evt_o,
  output logic             auto_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             full, wr_ok;
  logic [CNT_W-1:0] cnt_inc;

  assign full          = (cnt_q == CNT_W'(FIFO_DEPTH));
  assign wr_ok         = wr_en_i && !locked_i && !full;
  assign overrun_evt_o = wr_en_i && (locked_i || full);
  assign cnt_inc       = cnt_q + CNT_W'(1);
  assign auto_evt_o    = auto_commit_i && wr_ok && (cnt_inc == max_pkt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (flush_i && !locked_i)  cnt_q <= '0;
    else if (wr_ok)                 cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;

  a_r2_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FIFO_DEPTH));
  a_r5_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && locked_i && !clr_i) |=> $stable(cnt_q));
  a_r12_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !locked_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tx_retry_ctr.sv
module tx_retry_ctr #(
  parameter int unsigned NAK_W     = 8,
  parameter int unsigned ERR_TRIES = 3,
  localparam int unsigned ERR_W    = $clog2(ERR_TRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             nak_evt_i,
  input  logic             err_evt_i,
  input  logic [NAK_W-1:0] nak_limit_i,
  output logic             nak_hit_o,
  output logic             err_hit_o
);
  logic [NAK_W-1:0] nak_cnt_q;
  logic [ERR_W-1:0] err_cnt_q;
  logic [NAK_W:0]   nak_next;

  assign nak_next  = {1'b0, nak_cnt_q} + (NAK_W+1)'(1);
  assign nak_hit_o = (nak_limit_i != '0) && (nak_next >= {1'b0, nak_limit_i});
  assign err_hit_o = (err_cnt_q == ERR_W'(ERR_TRIES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nak_cnt_q <= '0;
      err_cnt_q <= '0;
    end else if (start_i) begin
      nak_cnt_q <= '0;
      err_cnt_q <= '0;
    end else begin
      if (nak_evt_i && !(&nak_cnt_q)) nak_cnt_q <= nak_cnt_q + NAK_W'(1);
      if (err_evt_i && !err_hit_o)    err_cnt_q <= err_cnt_q + ERR_W'(1);
    end
  end

  a_r11_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (nak_cnt_q == '0 && err_cnt_q == '0));
  a_r10_err_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_q < ERR_W'(ERR_TRIES));
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import host_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic       auto_evt_i,
  input  logic       overrun_evt_i,
  input  logic       status_clr_i,
  input  logic       txn_done_i,
  input  logic [1:0] txn_resp_i,
  input  logic       nak_hit_i,
  input  logic       err_hit_i,
  output logic       start_o,
  output logic       nak_evt_o,
  output logic       err_evt_o,
  output logic       fifo_clr_o,
  output logic       txn_req_o,
  output logic       ready_o,
  output logic       tx_irq_o,
  output logic       stalled_o,
  output logic       error_o,
  output logic       nak_to_o,
  output logic       overrun_o
);
  seq_state_e state_q, state_d;
  logic ready_q, ready_d;
  logic irq_q;
  logic stalled_q, error_q, nak_to_q, overrun_q;
  logic take, ack_evt, stall_evt, nak_abort, err_abort, finish;
  resp_e resp;

  assign resp      = resp_e'(txn_resp_i);
  assign take      = (state_q == ST_BUSY) && txn_done_i;
  assign ack_evt   = take && (resp == RESP_ACK);
  assign stall_evt = take && (resp == RESP_STALL);
  assign nak_evt_o = take && (resp == RESP_NAK);
  assign err_evt_o = take && (resp == RESP_ERR);
  assign nak_abort = nak_evt_o && nak_hit_i;
  assign err_abort = err_evt_o && err_hit_i;
  assign finish    = ack_evt || stall_evt || nak_abort || err_abort;
  assign start_o   = (state_q == ST_IDLE) && ready_q;
  assign fifo_clr_o = ack_evt || err_abort;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ready_q) state_d = ST_BUSY;
      ST_BUSY: if (finish)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ready_d = ready_q;
    if (finish)                               ready_d = 1'b0;
    else if (!ready_q && (commit_i || auto_evt_i)) ready_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ready_q   <= 1'b0;
      irq_q     <= 1'b0;
      stalled_q <= 1'b0;
      error_q   <= 1'b0;
      nak_to_q  <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ready_q   <= ready_d;
      irq_q     <= finish;
      stalled_q <= stall_evt     || (stalled_q && !status_clr_i);
      error_q   <= err_abort     || (error_q   && !status_clr_i);
      nak_to_q  <= nak_abort     || (nak_to_q  && !status_clr_i);
      overrun_q <= overrun_evt_i || (overrun_q && !status_clr_i);
    end
  end

  assign txn_req_o = (state_q == ST_BUSY);
  assign ready_o   = ready_q;
  assign tx_irq_o  = irq_q;
  assign stalled_o = stalled_q;
  assign error_o   = error_q;
  assign nak_to_o  = nak_to_q;
  assign overrun_o = overrun_q;

  a_r3_req_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_req_o |-> ready_o);
  a_r6_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);
  a_r9_stall_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_req_o && txn_done_i && txn_resp_i == 2'd2) |=> (stalled_o && !txn_req_o && tx_irq_o));
  a_r7_nak_retries: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_req_o && txn_done_i && txn_resp_i == 2'd1 && !nak_hit_i) |=> txn_req_o);
  a_r5_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && overrun_evt_i) |=> overrun_o);
endmodule

// File: rtl/host_out_tx_seq.sv
module host_out_tx_seq #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned NAK_W      = 8,
  parameter int unsigned ERR_TRIES  = 3,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             flush_i,
  input  logic             commit_i,
  input  logic             auto_commit_i,
  input  logic [CNT_W-1:0] max_pkt_i,
  input  logic [NAK_W-1:0] nak_limit_i,
  input  logic             status_clr_i,
  output logic             txn_req_o,
  output logic [CNT_W-1:0] txn_len_o,
  input  logic             txn_done_i,
  input  logic [1:0]       txn_resp_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] fifo_cnt_o,
  output logic             tx_irq_o,
  output logic             stalled_o,
  output logic             error_o,
  output logic             nak_to_o,
  output logic             overrun_o
);
  logic overrun_evt, auto_evt, fifo_clr;
  logic start, nak_evt, err_evt, nak_hit, err_hit;
  logic ready;

  tx_fifo_cnt #(.FIFO_DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_en_i       (wr_en_i),
    .locked_i      (ready),
    .flush_i       (flush_i),
    .clr_i         (fifo_clr),
    .auto_commit_i (auto_commit_i),
    .max_pkt_i     (max_pkt_i),
    .cnt_o         (fifo_cnt_o),
    .overrun_evt_o (overrun_evt),
    .auto_evt_o    (auto_evt)
  );

  tx_retry_ctr #(.NAK_W(NAK_W), .ERR_TRIES(ERR_TRIES)) u_retry (
    .clk_i, .rst_ni,
    .start_i     (start),
    .nak_evt_i   (nak_evt),
    .err_evt_i   (err_evt),
    .nak_limit_i (nak_limit_i),
    .nak_hit_o   (nak_hit),
    .err_hit_o   (err_hit)
  );

  tx_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .commit_i      (commit_i),
    .auto_evt_i    (auto_evt),
    .overrun_evt_i (overrun_evt),
    .status_clr_i  (status_clr_i),
    .txn_done_i    (txn_done_i),
    .txn_resp_i    (txn_resp_i),
    .nak_hit_i     (nak_hit),
    .err_hit_i     (err_hit),
    .start_o       (start),
    .nak_evt_o     (nak_evt),
    .err_evt_o     (err_evt),
    .fifo_clr_o    (fifo_clr),
    .txn_req_o     (txn_req_o),
    .ready_o       (ready),
    .tx_irq_o      (tx_irq_o),
    .stalled_o     (stalled_o),
    .error_o       (error_o),
    .nak_to_o      (nak_to_o),
    .overrun_o     (overrun_o)
  );

  assign ready_o   = ready;
  assign txn_len_o = fifo_cnt_o;

  a_r6_ack_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_req_o && txn_done_i && txn_resp_i == 2'd0) |=> (!ready_o && fifo_cnt_o == '0 && tx_irq_o));
  a_r10_err_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> (fifo_cnt_o == '0 && !ready_o));
endmodule

// File: tb/host_out_tx_seq_tb.sv
module host_out_tx_seq_tb;
  localparam int DEPTH = 16;
  localparam int NW    = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, flush = 0, commit = 0, auto_c = 0, sclr = 0;
  logic [CW-1:0] max_pkt = CW'(8);
  logic [NW-1:0] nak_lim = '0;
  logic txn_done = 0;
  logic [1:0] txn_resp = '0;
  logic txn_req, ready, irq, stalled, error, nak_to, overrun;
  logic [CW-1:0] txn_len, cnt;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  host_out_tx_seq #(.FIFO_DEPTH(DEPTH), .NAK_W(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .flush_i(flush),
    .commit_i(commit), .auto_commit_i(auto_c), .max_pkt_i(max_pkt),
    .nak_limit_i(nak_lim), .status_clr_i(sclr), .txn_req_o(txn_req),
    .txn_len_o(txn_len), .txn_done_i(txn_done), .txn_resp_i(txn_resp),
    .ready_o(ready), .fifo_cnt_o(cnt), .tx_irq_o(irq), .stalled_o(stalled),
    .error_o(error), .nak_to_o(nak_to), .overrun_o(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin wr_en = 1; step(); end
    wr_en = 0;
  endtask

  task automatic do_commit();
    commit = 1; step(); commit = 0;
  endtask

  task automatic respond(input logic [1:0] r);
    txn_done = 1; txn_resp = r; step(); txn_done = 0;
  endtask

  task automatic clear_status();
    sclr = 1; step(); sclr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "cnt", cnt, 0);
    chk("R1", "flags", {ready, txn_req, irq, stalled, error, nak_to, overrun}, 0);
  endtask

  task automatic t_fill_and_full();
    write_n(5);
    chk("R2", "cnt after 5", cnt, 5);
    flush = 1; step(); flush = 0;
    chk("R12", "flush idle", cnt, 0);
    write_n(DEPTH);
    chk("R2", "cnt full", cnt, DEPTH);
    chk("R2", "no overrun yet", overrun, 0);
    write_n(1);
    chk("R2", "cnt stays full", cnt, DEPTH);
    chk("R2", "overrun on full", overrun, 1);
    clear_status();
    chk("R13", "overrun cleared", overrun, 0);
    flush = 1; step(); flush = 0;
  endtask

  task automatic t_commit_ack();
    write_n(6);
    do_commit();
    chk("R3", "ready after commit", ready, 1);
    chk("R3", "req not yet", txn_req, 0);
    step();
    chk("R3", "req raised", txn_req, 1);
    chk("R3", "len", txn_len, 6);
    write_n(2);
    chk("R5", "cnt frozen", cnt, 6);
    chk("R5", "overrun", overrun, 1);
    flush = 1; step(); flush = 0;
    chk("R12", "flush ignored while ready", cnt, 6);
    respond(2'd0);
    chk("R6", "ready cleared", ready, 0);
    chk("R6", "req dropped", txn_req, 0);
    chk("R6", "cnt zero", cnt, 0);
    chk("R6", "irq pulse", irq, 1);
    step();
    chk("R6", "irq one cycle", irq, 0);
    clear_status();
  endtask

  task automatic t_auto_commit();
    auto_c = 1; max_pkt = CW'(8);
    write_n(7);
    chk("R4", "not ready at 7", ready, 0);
    write_n(1);
    chk("R4", "ready at max", ready, 1);
    chk("R4", "cnt at max", cnt, 8);
    step();
    chk("R4", "req", txn_req, 1);
    respond(2'd0);
    auto_c = 0;
    chk("R4", "ack done", cnt, 0);
  endtask

  task automatic t_nak_limit();
    nak_lim = NW'(3);
    write_n(4); do_commit(); step();
    respond(2'd1);
    respond(2'd1);
    chk("R7", "req held after 2 naks", txn_req, 1);
    chk("R7", "no naklim yet", nak_to, 0);
    respond(2'd1);
    chk("R7", "naklim set", nak_to, 1);
    chk("R7", "ready cleared", ready, 0);
    chk("R7", "irq", irq, 1);
    chk("R7", "cnt kept", cnt, 4);
    clear_status();
    chk("R13", "naklim cleared", nak_to, 0);
  endtask

  task automatic t_nak_unbounded();
    nak_lim = '0;
    do_commit(); step();
    for (int i = 0; i < 20; i++) respond(2'd1);
    chk("R8", "req after 20 naks", txn_req, 1);
    chk("R8", "no naklim", nak_to, 0);
    respond(2'd0);
    chk("R8", "finished by ack", cnt, 0);
  endtask

  task automatic t_stall();
    write_n(3); do_commit(); step();
    respond(2'd2);
    chk("R9", "stalled", stalled, 1);
    chk("R9", "req dropped", txn_req, 0);
    chk("R9", "ready cleared", ready, 0);
    chk("R9", "irq", irq, 1);
    chk("R9", "cnt kept", cnt, 3);
    step(); step();
    chk("R9", "no retry", txn_req, 0);
    clear_status();
    chk("R13", "stall cleared", stalled, 0);
  endtask

  task automatic t_errors();
    do_commit(); step();
    respond(2'd3);
    respond(2'd3);
    chk("R10", "req after 2 errors", txn_req, 1);
    chk("R10", "no error yet", error, 0);
    respond(2'd0);
    chk("R11", "ack after 2 errors", cnt, 0);
    write_n(5); do_commit(); step();
    respond(2'd3);
    respond(2'd3);
    chk("R11", "counts restarted", error, 0);
    chk("R11", "req held", txn_req, 1);
    respond(2'd3);
    chk("R10", "error set", error, 1);
    chk("R10", "flushed", cnt, 0);
    chk("R10", "ready cleared", ready, 0);
    chk("R10", "irq", irq, 1);
    clear_status();
    chk("R13", "error cleared", error, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_fill_and_full();
    t_commit_ack();
    t_auto_commit();
    t_nak_limit();
    t_nak_unbounded();
    t_stall();
    t_errors();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule